// File: doc/BRIEF.md
# Edge-Set Interrupt Flag Register

This block is the interrupt flag word of a clock and power status unit. Twelve live status inputs feed it, such as oscillator-ready, loop-lock and supply-detection signals. Each input has one flag. A flag is set when its input goes from low to high, not while the input stays high. Software reads the word over a simple register bus and clears flags by writing ones to them. A twelve-bit enable mask chooses which flags drive the single interrupt request output.

On reset, each flag can be preloaded from a startup configuration vector. This lets a condition that already held at power-up appear as a pending flag, and software must clear it before it relies on that interrupt. Reset also loads the edge history from the live status vector. As a result, an input that is already high when reset is released does not produce an edge of its own.

Reset is synchronous and active low. The read path is combinational and returns the flag values held before any write in the same cycle takes effect.

Top module: `evt_flag_reg`

## Requirements
- R1: The flag word is decoded at byte offset 0x08. A read at that offset returns flag n in bit n for n = 0..11. A read at any other offset returns zero.
- R2: Bits 31 down to 12 of the flag word always read as zero. Writing ones to them changes no flag.
- R3: A flag is set at the first clock edge that samples its status input high after it was sampled low.
- R4: A status input that stays high does not set its flag again once the flag has been cleared.
- R5: A write at offset 0x08 with a one in bit n clears flag n at that clock edge. A write at any other offset clears nothing.
- R6: A write with a zero in bit n leaves flag n unchanged.
- R7: The interrupt output is high exactly when at least one flag and its enable bit are both one. It follows mask changes in the same cycle.
- R8: While reset is held, each flag loads its startup preset bit and the edge history loads the live status. A status input that is high across the release of reset sets no flag.
- R9: If a rising edge and a write-one clear hit the same flag in one cycle, the flag ends up set.
- R10: A read in a cycle that also writes returns the flag values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 8 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe for this cycle |
| busWrData | input | 32 | Write data, ones clear flags |
| busRdData | output | 32 | Read data, combinational |
| statusIn | input | 12 | Live status inputs |
| presetIn | input | 12 | Startup flag preset, sampled during reset |
| enableMask | input | 12 | Per-flag interrupt enables |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume that the status, preset, mask and bus inputs are stable and known at each rising clock edge. They also assume that reset is held low from time zero for at least one edge. The stimulus meets these assumptions by changing every input one nanosecond after a rising edge and by starting with reset asserted for several cycles. Outputs are sampled in the middle of the cycle, after all registers and combinational paths have settled.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
  // Strobes from bus decode to the flag datapath.
  typedef struct packed {
    logic wrHit;   // write addressed to the flag word
    logic rdHit;   // read addressed to the flag word
  } flagStrobes_t;
endpackage

// File: rtl/evt_flag_ctrl.sv
module evt_flag_ctrl
  import evt_flag_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 12,
  parameter logic [ADDR_W-1:0] FLAG_OFFSET = 8'h08
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [NUM_FLAGS-1:0] flagQ,
  output flagStrobes_t         strobes,
  output logic [DATA_W-1:0]    busRdData
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  logic addrHit;
  assign addrHit = (busAddr == FLAG_OFFSET);

  always_comb begin
    strobes       = '0;
    strobes.wrHit = addrHit && busWrEn;
    strobes.rdHit = addrHit;
  end

  // Read returns the registered flags: writes land only at the clock edge.
  always_comb begin
    if (strobes.rdHit) busRdData = {{PAD_W{1'b0}}, flagQ};
    else               busRdData = '0;
  end

  // R1: other offsets read as zero.
  p_other_offset_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != FLAG_OFFSET) |-> (busRdData == '0));

  // R10: a read in a write cycle still shows the flags of the previous edge.
  p_read_prewrite_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdHit |-> (busRdData[NUM_FLAGS-1:0] == flagQ));
endmodule

// File: rtl/evt_flag_datapath.sv
module evt_flag_datapath
  import evt_flag_pkg::*;
#(
  parameter int NUM_FLAGS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStrobes_t         strobes,
  input  logic [NUM_FLAGS-1:0] wrBits,
  input  logic [NUM_FLAGS-1:0] statusIn,
  input  logic [NUM_FLAGS-1:0] presetIn,
  input  logic [NUM_FLAGS-1:0] enableMask,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic                 irqOut
);
  logic [NUM_FLAGS-1:0] prevQ;
  logic [NUM_FLAGS-1:0] riseBits;
  logic [NUM_FLAGS-1:0] clrBits;
  logic [NUM_FLAGS-1:0] flagNext;

  genvar i;
  generate
    for (i = 0; i < NUM_FLAGS; i++) begin : g_cell
      assign riseBits[i] = statusIn[i] & ~prevQ[i];
      assign clrBits[i]  = strobes.wrHit & wrBits[i];
      // Set dominates clear so a coincident event is never dropped.
      assign flagNext[i] = riseBits[i] | (flagQ[i] & ~clrBits[i]);

      p_set_on_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
        (statusIn[i] && !prevQ[i]) |=> flagQ[i]);

      p_clear_on_one_r5: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.wrHit && wrBits[i] && !(statusIn[i] && !prevQ[i])) |=> !flagQ[i]);

      p_hold_otherwise_r6: assert property (@(posedge clk) disable iff (!rstN)
        (!(strobes.wrHit && wrBits[i]) && !(statusIn[i] && !prevQ[i]))
          |=> (flagQ[i] == $past(flagQ[i])));

      p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.wrHit && wrBits[i] && statusIn[i] && !prevQ[i]) |=> flagQ[i]);

      p_high_no_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
        (prevQ[i] && statusIn[i] && !flagQ[i] && !(strobes.wrHit && wrBits[i]))
          |=> !flagQ[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= presetIn;
      prevQ <= statusIn;
    end else begin
      flagQ <= flagNext;
      prevQ <= statusIn;
    end
  end

  assign irqOut = |(flagQ & enableMask);

  // R7: no request can exist with every enable low.
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enableMask != '0));

  // R8: the first cycle out of reset shows the preset.
  p_preset_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (flagQ == $past(presetIn)));
endmodule

// File: rtl/evt_flag_reg.sv
module evt_flag_reg
  import evt_flag_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 12,
  parameter logic [ADDR_W-1:0] FLAG_OFFSET = 8'h08
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_FLAGS-1:0] statusIn,
  input  logic [NUM_FLAGS-1:0] presetIn,
  input  logic [NUM_FLAGS-1:0] enableMask,
  output logic                 irqOut
);
  flagStrobes_t         strobes;
  logic [NUM_FLAGS-1:0] flagQ;
  logic                 unusedWrBits;

  // R2: reserved write bits reach no storage.
  assign unusedWrBits = ^busWrData[DATA_W-1:NUM_FLAGS];

  evt_flag_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS), .FLAG_OFFSET(FLAG_OFFSET)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .flagQ(flagQ), .strobes(strobes), .busRdData(busRdData)
  );

  evt_flag_datapath #(.NUM_FLAGS(NUM_FLAGS)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrBits(busWrData[NUM_FLAGS-1:0]), .statusIn(statusIn),
    .presetIn(presetIn), .enableMask(enableMask),
    .flagQ(flagQ), .irqOut(irqOut)
  );
endmodule

// File: tb/evt_flag_reg_tb.sv
module evt_flag_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h08;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [11:0] statusIn = '0;
  logic [11:0] presetIn = '0;
  logic [11:0] enableMask = '0;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  evt_flag_reg dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .statusIn(statusIn),
    .presetIn(presetIn), .enableMask(enableMask), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [11:0] status;
    logic        wr;
    logic [31:0] wdata;
    logic [11:0] mask;
    logic [11:0] expFlags;
    logic        expIrq;
  } vec_t;

  // Walked from flags = 0, status = 0 after reset.
  localparam vec_t VECS [9] = '{
    '{12'h001, 1'b0, 32'h0,        12'h001, 12'h001, 1'b1}, // R3 edge sets
    '{12'h001, 1'b1, 32'h1,        12'h001, 12'h000, 1'b0}, // R5 clear
    '{12'h001, 1'b0, 32'h0,        12'h001, 12'h000, 1'b0}, // R4 held high
    '{12'h000, 1'b0, 32'h0,        12'h001, 12'h000, 1'b0},
    '{12'h0F0, 1'b1, 32'h0,        12'h100, 12'h0F0, 1'b0}, // R6 zero write, R7 masked
    '{12'h0F0, 1'b1, 32'h030,      12'h080, 12'h0C0, 1'b1}, // R5 R6 partial
    '{12'h8F1, 1'b1, 32'h801,      12'h800, 12'h8C1, 1'b1}, // R9 set wins
    '{12'h000, 1'b1, 32'hFFFFF000, 12'h000, 12'h8C1, 1'b0}, // R2 reserved write
    '{12'h000, 1'b1, 32'h00000FFF, 12'hFFF, 12'h000, 1'b0}  // R5 clear all
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R8 reset state with zero preset
    check("R8 reset flags", busRdData, 32'h0);
    check("R7 reset irq", {31'b0, irqOut}, 32'h0);

    foreach (VECS[k]) begin
      statusIn   = VECS[k].status;
      busWrEn    = VECS[k].wr;
      busWrData  = VECS[k].wdata;
      enableMask = VECS[k].mask;
      tick();
      busWrEn = 1'b0;
      check($sformatf("R3/R4/R5/R6/R9/R2 vector %0d flags", k), busRdData, {20'b0, VECS[k].expFlags});
      check($sformatf("R7 vector %0d irq", k), {31'b0, irqOut}, {31'b0, VECS[k].expIrq});
    end

    // R1 other offset reads zero, R5 write elsewhere clears nothing
    statusIn = 12'h00C; tick();           // flags = 00C
    statusIn = 12'h000;
    busAddr = 8'h0C; busWrEn = 1'b1; busWrData = 32'hFFFFFFFF;
    #1;
    check("R1 read other offset", busRdData, 32'h0);
    tick();
    busWrEn = 1'b0; busAddr = 8'h08;
    #1;
    check("R5 write at other offset", busRdData, 32'h00C);

    // R7 irq follows mask in same cycle
    enableMask = 12'h008; #1;
    check("R7 mask on", {31'b0, irqOut}, 32'h1);
    enableMask = 12'h001; #1;
    check("R7 mask off", {31'b0, irqOut}, 32'h0);

    // R10 read during a clear-write shows old value, R2 upper bits zero
    busWrEn = 1'b1; busWrData = 32'hFFFFFFFF; #1;
    check("R10 read in write cycle", busRdData, 32'h00C);
    tick();
    busWrEn = 1'b0; #1;
    check("R2 reserved bits read zero", busRdData, 32'h0);

    // R8 preset and high status across reset release
    rstN = 1'b0; presetIn = 12'h005; statusIn = 12'h002;
    repeat (2) tick();
    rstN = 1'b1;
    tick();
    check("R8 preset loaded", busRdData, 32'h005);
    tick();
    check("R8 high status no edge", busRdData, 32'h005);
    enableMask = 12'h004; #1;
    check("R8 R7 preset drives irq", {31'b0, irqOut}, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule